// File: doc/BRIEF.md
# Gated programmable clock divider

This block derives two clocks from one source clock: a card-interface clock and a companion high-speed clock. A single 10-bit control register, written and read over a simple synchronous port, holds a power-of-two prescale code, a post-divide code and two stop bits, one for each output. The card clock divides the source by the product of the prescale ratio (1, 2, 4, 8 or 16) and the post-divide ratio (2 or 4), so its ratio is any power of two from 2 to 64. The high-speed clock divides the source by twice the prescale ratio. It is allowed to run only when the prescale ratio is 1 or 2.

Two single-cycle requests manage gating. A disable request stops both outputs and keeps the divide fields. An enable request checks the stored fields against the legal set, releases the card clock, and releases the high-speed clock only where the prescale allows it. An illegal write or an enable request with unknown fields raises an error flag and leaves both outputs stopped. Register changes reach the outputs only when an internal phase counter restarts, which is a point where both outputs are low. This prevents runt pulses.

Top module: `cardclk_divider`

## Requirements
- R1: After reset, the readback is 0x301 (both stop bits set, prescale code 0, post-divide code 1), `running` and `cfg_err` are 0, and both clock outputs are low.
- R2: A legal write stores the value. The readback then shows the high-speed stop at bit 9, the card stop at bit 8, the prescale code at bits 4:2 and the post-divide code at bits 1:0. Bits 7:5 read as 0, and `cfg_err` clears.
- R3: When running, the card clock has a period of 2^p × (2 if the post code is 0, 4 if it is 1) source cycles, where p is the prescale code. High and low phases are equal.
- R4: When running, the high-speed clock has a period of 2 × 2^p source cycles with equal phases. An output whose stop bit is set is held low.
- R5: A write is illegal when the prescale code is above 4, when the post code is above 1, or when the prescale code is 2 or more with bit 9 clear. An illegal write sets `cfg_err`, stores the divide fields with both stop bits set, and leaves both outputs stopped.
- R6: A disable request, with no write in the same cycle, sets both stop bits and leaves bits 4:0 unchanged.
- R7: An enable request with legal fields clears the card stop and sets the high-speed stop exactly when the prescale code is 2 or more. It also clears `cfg_err`.
- R8: An enable request while the stored fields are out of range is rejected. `cfg_err` is set, both stop bits stay set and both outputs stay low.
- R9: `running` is 1 exactly when both stop bits read as 0.
- R10: A new ratio or stop setting reaches the outputs only at the restart of the phase counter, where both outputs are low. Every completed high or low phase therefore has the old or the new half-period length, never a shorter one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 10 | Value to write |
| dis_req | input | 1 | Request to stop both outputs (one cycle) |
| en_req | input | 1 | Request to restore outputs from the stored fields (one cycle) |
| rd_data | output | 10 | Control register readback |
| card_clk | output | 1 | Divided card-interface clock |
| hs_clk | output | 1 | Divided high-speed clock |
| running | output | 1 | Both outputs enabled |
| cfg_err | output | 1 | Last write or enable request was rejected |

## Verification
A wrong register state shows on `rd_data`, `running` and `cfg_err` one cycle after the write or request that caused it. A wrong ratio or a wrong gate shows on the clock outputs within one phase-counter restart, which is at most 64 source cycles. A late or early switch of the applied configuration shows as a high or low phase whose length matches neither the old nor the new half-period. The bench therefore measures every completed phase across a ratio change, not only the steady-state ratio.

// File: rtl/cdiv_pkg.sv
// Shared constants, configuration type and legality helpers for the
// gated clock divider. Assumes power-of-two ratios only.
package cdiv_pkg;
    localparam int REG_W         = 10;
    localparam int PRE_W         = 3;
    localparam int POST_W        = 2;
    localparam int PRE_MAX       = 4;   // highest legal prescale code
    localparam int POST_MAX      = 1;   // highest legal post-divide code
    localparam int HS_LIMIT      = 2;   // first prescale code that forces the high-speed stop
    localparam int BIT_HS_STOP   = 9;
    localparam int BIT_CARD_STOP = 8;
    localparam int PRE_LSB       = 2;
    localparam int POST_LSB      = 0;
    localparam int CNT_W         = PRE_MAX + POST_MAX + 1;
    localparam int IDX_W         = $clog2(CNT_W);
    localparam int N_LANES       = 2;
    localparam int LANE_CARD     = 0;
    localparam int LANE_HS       = 1;

    typedef struct packed {
        logic              hs_stop;
        logic              card_stop;
        logic [PRE_W-1:0]  pre;
        logic [POST_W-1:0] post;
    } cfg_t;

    // True when both divide codes lie inside the legal range.
    function automatic logic fields_ok(input logic [PRE_W-1:0] pre, input logic [POST_W-1:0] post);
        return (int'(pre) <= PRE_MAX) && (int'(post) <= POST_MAX);
    endfunction

    // True when the prescale code requires the high-speed output to be stopped.
    function automatic logic hs_must_stop(input logic [PRE_W-1:0] pre);
        return int'(pre) >= HS_LIMIT;
    endfunction
endpackage

// File: rtl/cdiv_ctrl_reg.sv
// Control register: accepts writes, disable and enable requests, enforces
// the legal encodings and flags rejected operations.
// Assumes requests are single-cycle; a write takes priority over disable,
// and disable takes priority over enable.
module cdiv_ctrl_reg
    import cdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             dis_req,
    input  logic             en_req,
    output cfg_t             cfg,
    output logic             cfg_err
);
    cfg_t wr_cfg;
    logic wr_legal;
    logic cur_ok;

    // Decode the incoming write and judge its legality.
    always_comb begin
        wr_cfg.hs_stop   = wr_data[BIT_HS_STOP];
        wr_cfg.card_stop = wr_data[BIT_CARD_STOP];
        wr_cfg.pre       = wr_data[PRE_LSB +: PRE_W];
        wr_cfg.post      = wr_data[POST_LSB +: POST_W];
        wr_legal = fields_ok(wr_cfg.pre, wr_cfg.post) &&
                   (!hs_must_stop(wr_cfg.pre) || wr_cfg.hs_stop);
        cur_ok   = fields_ok(cfg.pre, cfg.post);
    end

    // Register update with write > disable > enable priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.hs_stop   <= 1'b1;
            cfg.card_stop <= 1'b1;
            cfg.pre       <= '0;
            cfg.post      <= POST_W'(1);
            cfg_err       <= 1'b0;
        end else if (wr_en) begin
            cfg.pre  <= wr_cfg.pre;
            cfg.post <= wr_cfg.post;
            if (wr_legal) begin
                cfg.hs_stop   <= wr_cfg.hs_stop;
                cfg.card_stop <= wr_cfg.card_stop;
                cfg_err       <= 1'b0;
            end else begin
                cfg.hs_stop   <= 1'b1;
                cfg.card_stop <= 1'b1;
                cfg_err       <= 1'b1;
            end
        end else if (dis_req) begin
            cfg.hs_stop   <= 1'b1;
            cfg.card_stop <= 1'b1;
        end else if (en_req) begin
            if (cur_ok) begin
                cfg.hs_stop   <= hs_must_stop(cfg.pre);
                cfg.card_stop <= 1'b0;
                cfg_err       <= 1'b0;
            end else begin
                cfg.hs_stop   <= 1'b1;
                cfg.card_stop <= 1'b1;
                cfg_err       <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/cdiv_phase_cnt.sv
// Free-running binary phase counter. Bit k toggles every 2^k source
// cycles, so it carries a divide-by-2^(k+1) square wave. wrap marks the
// last count before restart, where every bit is about to go low.
module cdiv_phase_cnt #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             wrap
);
    logic [CNT_W-1:0] cnt;

    // Next count and restart detect.
    always_comb begin
        cnt_nxt = cnt + CNT_W'(1);
        wrap    = &cnt;
    end

    // Count every source cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt_nxt;
    end
endmodule

// File: rtl/cdiv_out_lane.sv
// One gated output: holds the applied tap index and stop bit, reloads
// them from the request only at counter restart, and registers the
// selected counter bit as a glitch-free clock output.
// Assumes req_idx < CNT_W whenever req_stop is clear.
module cdiv_out_lane #(
    parameter int CNT_W = 6,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wrap,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  logic [IDX_W-1:0] req_idx,
    input  logic             req_stop,
    output logic             clk_out,
    output logic             app_stop,
    output logic [IDX_W-1:0] app_idx
);
    logic [IDX_W-1:0] sel_idx;
    logic             sel_stop;
    logic             tap;

    // Choose the settings for the coming cycle and pick the counter bit.
    always_comb begin
        sel_idx  = wrap ? req_idx  : app_idx;
        sel_stop = wrap ? req_stop : app_stop;
        tap      = 1'b0;
        for (int i = 0; i < CNT_W; i++) begin
            if (sel_idx == IDX_W'(i)) tap = cnt_nxt[i];
        end
    end

    // Apply settings at restart and drive the registered output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            app_idx  <= '0;
            app_stop <= 1'b1;
            clk_out  <= 1'b0;
        end else begin
            app_idx  <= sel_idx;
            app_stop <= sel_stop;
            clk_out  <= tap & ~sel_stop;
        end
    end
endmodule

// File: rtl/cardclk_divider.sv
// Top of the gated programmable clock divider: control register, shared
// phase counter and one output lane each for the card and high-speed
// clocks. Assumes a single source clock and synchronous active-low reset.
module cardclk_divider
    import cdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             dis_req,
    input  logic             en_req,
    output logic [REG_W-1:0] rd_data,
    output logic             card_clk,
    output logic             hs_clk,
    output logic             running,
    output logic             cfg_err
);
    cfg_t                            cfg;
    logic [CNT_W-1:0]                cnt_nxt;
    logic                            wrap;
    logic                            ok;
    logic [N_LANES-1:0]              lane_stop;
    logic [N_LANES-1:0]              lane_out;
    logic [N_LANES-1:0]              app_stop;
    logic [N_LANES-1:0][IDX_W-1:0]   lane_idx;
    logic [N_LANES-1:0][IDX_W-1:0]   app_idx;

    cdiv_ctrl_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .dis_req (dis_req),
        .en_req  (en_req),
        .cfg     (cfg),
        .cfg_err (cfg_err)
    );

    cdiv_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_nxt (cnt_nxt),
        .wrap    (wrap)
    );

    // Map the register onto per-lane tap indices and stops; readback packing.
    always_comb begin
        ok                  = fields_ok(cfg.pre, cfg.post);
        lane_idx[LANE_CARD] = ok ? (IDX_W'(cfg.pre) + IDX_W'(cfg.post)) : '0;
        lane_idx[LANE_HS]   = ok ? IDX_W'(cfg.pre) : '0;
        lane_stop[LANE_CARD] = cfg.card_stop;
        lane_stop[LANE_HS]   = cfg.hs_stop;
        rd_data                      = '0;
        rd_data[BIT_HS_STOP]         = cfg.hs_stop;
        rd_data[BIT_CARD_STOP]       = cfg.card_stop;
        rd_data[PRE_LSB +: PRE_W]    = cfg.pre;
        rd_data[POST_LSB +: POST_W]  = cfg.post;
        running  = ~cfg.hs_stop & ~cfg.card_stop;
        card_clk = lane_out[LANE_CARD];
        hs_clk   = lane_out[LANE_HS];
    end

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        cdiv_out_lane #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .wrap     (wrap),
            .cnt_nxt  (cnt_nxt),
            .req_idx  (lane_idx[g]),
            .req_stop (lane_stop[g]),
            .clk_out  (lane_out[g]),
            .app_stop (app_stop[g]),
            .app_idx  (app_idx[g])
        );
    end
endmodule

// File: rtl/cdiv_checker.sv
// Property checker for the gated clock divider, bound to the top module.
module cdiv_checker
    import cdiv_pkg::*;
(
    input logic                          clk,
    input logic                          rst_n,
    input logic                          wr_en,
    input logic                          dis_req,
    input logic [REG_W-1:0]              rd_data,
    input logic                          card_clk,
    input logic                          hs_clk,
    input logic                          cfg_err,
    input logic [N_LANES-1:0]            app_stop,
    input logic [N_LANES-1:0][IDX_W-1:0] app_idx
);
    // R4: an applied card stop holds the card clock low.
    a_r4_card_gate: assert property (@(posedge clk) disable iff (!rst_n)
        app_stop[LANE_CARD] |-> !card_clk);

    // R4: an applied high-speed stop holds the high-speed clock low.
    a_r4_hs_gate: assert property (@(posedge clk) disable iff (!rst_n)
        app_stop[LANE_HS] |-> !hs_clk);

    // R5, R8: a flagged error always comes with both stop bits set.
    a_r5_err_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (rd_data[BIT_HS_STOP] && rd_data[BIT_CARD_STOP]));

    // R7: a prescale code of 2 or more never coexists with a running high-speed clock.
    a_r7_hs_stop_rule: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_data[PRE_LSB +: PRE_W]) >= HS_LIMIT) |-> rd_data[BIT_HS_STOP]);

    // R6: a disable request sets both stops and keeps the divide fields.
    a_r6_disable: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_req && !wr_en) |=> (rd_data[BIT_HS_STOP] && rd_data[BIT_CARD_STOP] &&
                                 rd_data[4:0] == $past(rd_data[4:0])));

    // R10: the applied settings change only where both outputs are low.
    a_r10_apply_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(app_idx) || !$stable(app_stop)) |-> (!card_clk && !hs_clk));
endmodule

bind cardclk_divider cdiv_checker chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .dis_req  (dis_req),
    .rd_data  (rd_data),
    .card_clk (card_clk),
    .hs_clk   (hs_clk),
    .cfg_err  (cfg_err),
    .app_stop (app_stop),
    .app_idx  (app_idx)
);

// File: tb/cardclk_divider_tb_top.sv
module cardclk_divider_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WIN        = 256;
    localparam int SETTLE     = 70;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [9:0] wr_data = '0;
    logic       dis_req = 1'b0;
    logic       en_req = 1'b0;
    logic [9:0] rd_data;
    logic       card_clk, hs_clk, running, cfg_err;

    int checks = 0;
    int errors = 0;

    int    q_ca[$], q_cb[$], q_ha[$], q_hb[$], q_set[$];
    string q_tag[$];
    int    pushed = 0;
    int    done   = 0;

    cardclk_divider dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .dis_req(dis_req), .en_req(en_req), .rd_data(rd_data),
        .card_clk(card_clk), .hs_clk(hs_clk), .running(running), .cfg_err(cfg_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Expected half-periods from the requirements (R3, R4).
    function automatic int card_half(int pre, int post);
        return ((1 << pre) * (post == 0 ? 2 : 4)) / 2;
    endfunction
    function automatic int hs_half(int pre);
        return 1 << pre;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic check_reg(string tag, int exp_rd, int exp_run, int exp_err);
        chk({tag, " rd_data"}, int'(rd_data), exp_rd);
        chk({tag, " running(R9)"}, int'(running), exp_run);
        chk({tag, " cfg_err"}, int'(cfg_err), exp_err);
    endtask

    task automatic do_write(int val);
        @(negedge clk);
        wr_en = 1'b1; wr_data = 10'(val);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_dis();
        @(negedge clk); dis_req = 1'b1;
        @(negedge clk); dis_req = 1'b0;
    endtask

    task automatic do_en();
        @(negedge clk); en_req = 1'b1;
        @(negedge clk); en_req = 1'b0;
    endtask

    // Push an expected clock shape and wait for the monitor to judge it.
    task automatic expect_clk(string tag, int ca, int cb, int ha, int hb, int settle);
        q_ca.push_back(ca); q_cb.push_back(cb);
        q_ha.push_back(ha); q_hb.push_back(hb);
        q_set.push_back(settle); q_tag.push_back(tag);
        pushed++;
        wait (done == pushed);
    endtask

    // Monitor: measures completed phase lengths of both outputs.
    initial begin
        forever begin
            int a[2], b[2], lvl[2], run[2], nrun[2], nbad[2], badv[2];
            bit first[2];
            int st;
            string tg;
            wait (q_ca.size() > 0);
            a[0] = q_ca.pop_front(); b[0] = q_cb.pop_front();
            a[1] = q_ha.pop_front(); b[1] = q_hb.pop_front();
            st = q_set.pop_front(); tg = q_tag.pop_front();
            repeat (st) @(negedge clk);
            for (int s = 0; s < WIN; s++) begin
                logic [1:0] v;
                @(negedge clk);
                v = {hs_clk, card_clk};
                for (int l = 0; l < 2; l++) begin
                    if (s == 0) begin
                        lvl[l] = int'(v[l]); run[l] = 1; first[l] = 1'b1;
                        nrun[l] = 0; nbad[l] = 0; badv[l] = 0;
                    end else if (int'(v[l]) == lvl[l]) begin
                        run[l]++;
                    end else begin
                        if (!first[l]) begin
                            nrun[l]++;
                            if (run[l] != a[l] && run[l] != b[l]) begin
                                nbad[l]++; badv[l] = run[l];
                            end
                        end
                        first[l] = 1'b0; lvl[l] = int'(v[l]); run[l] = 1;
                    end
                end
            end
            for (int l = 0; l < 2; l++) begin
                string nm;
                nm = (l == 0) ? "card" : "hs";
                checks++;
                if (a[l] == 0 && b[l] == 0) begin
                    if (nrun[l] != 0 || first[l] == 1'b0 || lvl[l] != 0) begin
                        errors++;
                        $display("FAIL %s %s stopped: actual level=%0d edges=%0d expected low, no edges",
                                 tg, nm, lvl[l], nrun[l]);
                    end
                end else if (nrun[l] < 2 || nbad[l] != 0) begin
                    errors++;
                    $display("FAIL %s %s half-period: actual=%0d (runs=%0d) expected=%0d or %0d",
                             tg, nm, badv[l], nrun[l], a[l], b[l]);
                end
            end
            done++;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Driver: stimulus sequence with expected results per requirement.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check_reg("R1 reset", 'h301, 0, 0);
        expect_clk("R1 outputs low", 0, 0, 0, 0, 0);

        // R2, R3, R4: fastest ratio, both running
        do_write('h000);
        check_reg("R2 write 0x000", 'h000, 1, 0);
        expect_clk("R3 R4 pre0 post0", card_half(0,0), card_half(0,0), hs_half(0), hs_half(0), SETTLE);

        // R2: bits 7:5 read zero; R3, R4 with pre1 post1
        do_write('h0E5);
        check_reg("R2 write 0x0E5", 'h005, 1, 0);
        expect_clk("R3 R4 pre1 post1", card_half(1,1), card_half(1,1), hs_half(1), hs_half(1), SETTLE);

        // R4: high-speed stopped by its own bit, card running
        do_write('h201);
        check_reg("R4 write 0x201", 'h201, 0, 0);
        expect_clk("R4 hs gated", card_half(0,1), card_half(0,1), 0, 0, SETTLE);

        // R3: prescale 16 with post 2
        do_write('h210);
        check_reg("R3 write 0x210", 'h210, 0, 0);
        expect_clk("R3 pre4 post0", card_half(4,0), card_half(4,0), 0, 0, SETTLE);

        // R10: switch from ratio 64 to ratio 4 without runts
        do_write('h211);
        expect_clk("R3 pre4 post1", card_half(4,1), card_half(4,1), 0, 0, SETTLE);
        do_write('h004);
        expect_clk("R10 switch 64->4", card_half(4,1), card_half(1,0), hs_half(1), hs_half(1), 0);

        // R6: disable keeps fields
        do_dis();
        check_reg("R6 disable", 'h304, 0, 0);
        expect_clk("R6 outputs stopped", 0, 0, 0, 0, SETTLE);

        // R7: enable restores both stops clear for prescale 1
        do_en();
        check_reg("R7 enable pre1", 'h004, 1, 0);
        expect_clk("R7 restored", card_half(1,0), card_half(1,0), hs_half(1), hs_half(1), SETTLE);

        // R7: enable with prescale 3 keeps the high-speed stop
        do_write('h30D);
        check_reg("R7 write stopped 0x30D", 'h30D, 0, 0);
        do_en();
        check_reg("R7 enable pre3", 'h20D, 0, 0);
        expect_clk("R7 pre3 post1", card_half(3,1), card_half(3,1), 0, 0, SETTLE);

        // R5: prescale code out of range
        do_write('h01C);
        check_reg("R5 prescale 7", 'h31C, 0, 1);
        expect_clk("R5 outputs stopped", 0, 0, 0, 0, SETTLE);

        // R8: enable with unknown fields is rejected
        do_en();
        check_reg("R8 enable rejected", 'h31C, 0, 1);
        expect_clk("R8 outputs stopped", 0, 0, 0, 0, SETTLE);

        // R2: legal write clears the error
        do_write('h000);
        check_reg("R2 error cleared", 'h000, 1, 0);

        // R5: prescale 3 with high-speed stop clear
        do_write('h00C);
        check_reg("R5 hs rule", 'h30C, 0, 1);

        // R5: post code 2
        do_write('h002);
        check_reg("R5 post 2", 'h302, 0, 1);
        expect_clk("R5 post 2 stopped", 0, 0, 0, 0, SETTLE);

        // R6: disable leaves an out-of-range field intact
        do_write('h003);
        do_dis();
        check_reg("R6 disable keeps fields", 'h303, 0, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule